// File: doc/BRIEF.md
# Fetch Thread Selector

This block decides, in every cycle, which hardware thread of a multithreaded front end may fetch. A tracker outside the block supplies a 3-bit state per thread and a mask of threads that are active. A one-bit policy input chooses between two modes. In fixed mode, thread 0 is always chosen. In rotating mode, the block keeps a fair ordering of all threads. The chosen thread ID and a valid flag are combinational functions of the current inputs and the stored ordering.

In rotating mode the block holds an ordered list of thread IDs. It scans the list from the head and grants the first thread that may fetch. When the grant is accepted, only that thread moves to the tail. Threads that were passed over keep their order relative to each other. When the block is built for a single thread, the policy input is ignored. The one thread is chosen when it is active and may fetch.

Top module: `fetch_thread_sel`

## Requirements
- R1: State codes on `thr_state` are 3 bits per thread, with thread t at bits [3t+2:3t]. Codes 0 (running), 1 (idle) and 2 (miss returned) may fetch. Codes 3 to 7 (miss pending, blocked, squashing, trap wait, quiesce) may not. A thread whose `thr_active` bit is 0 is never chosen in rotating mode.
- R2: In rotating mode (`policy_rr`=1), `sel_tid` is the first thread, scanning the list from its head, that is active and holds a fetchable code. `sel_valid` is then 1.
- R3: On a clock edge where `policy_rr`, `sel_valid` and `grant_accept` are all 1, the granted thread moves to the tail of the list. Entries ahead of it stay in place. Entries behind it move one place toward the head, keeping their order.
- R4: In rotating mode with no eligible thread, `sel_valid` is 0. `grant_accept` then leaves the list unchanged.
- R5: In fixed mode (`policy_rr`=0) with more than one thread, `sel_tid` is 0 and `sel_valid` is 1, whatever the states are. The list does not rotate.
- R6: After reset the list holds the thread IDs in ascending order. With all threads eligible and every grant accepted, the grants run 0, 1, 2, 3, 0.
- R7: `sel_tid` and `sel_valid` follow the inputs in the same cycle. A rotation shows in the selection from the cycle after the accepting edge.
- R8: With `NUM_THREADS`=1, `sel_valid` is 1 exactly when thread 0 is active and holds a fetchable code. `sel_tid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| thr_state | input | 3*NUM_THREADS | Per-thread state codes |
| thr_active | input | NUM_THREADS | Per-thread active mask |
| policy_rr | input | 1 | 0 = fixed thread 0, 1 = rotating list |
| grant_accept | input | 1 | The fetch stage takes the current grant |
| sel_tid | output | 2 | Chosen thread ID |
| sel_valid | output | 1 | Chosen thread ID is usable |

## Verification
The selection is combinational, so it is due in the same cycle as the inputs that produce it. The bench drives inputs just after the falling edge and samples the outputs 1 ns later, well before the next rising edge. A rotation is due one edge after an accepted grant. The bench's reference list is therefore updated only after that cycle's comparison. It is first seen in the following cycle's expected selection. A single-thread instance runs alongside the four-thread one and is checked in the same cycle.

// File: rtl/fsel_pkg.sv
package fsel_pkg;

  localparam int TID_W = 2;
  localparam int ST_W  = 3;

  typedef enum logic [ST_W-1:0] {
    TS_RUN       = 3'd0,
    TS_IDLE      = 3'd1,
    TS_MISS_DONE = 3'd2,
    TS_MISS_WAIT = 3'd3,
    TS_BLOCKED   = 3'd4,
    TS_SQUASH    = 3'd5,
    TS_TRAP      = 3'd6,
    TS_QUIESCE   = 3'd7
  } thr_state_e;

  function automatic logic can_fetch(input logic [ST_W-1:0] s);
    return (s == TS_RUN) || (s == TS_IDLE) || (s == TS_MISS_DONE);
  endfunction

endpackage

// File: rtl/fsel_elig.sv
module fsel_elig
  import fsel_pkg::*;
#(
  parameter int NUM_THREADS = 4
) (
  input  logic [NUM_THREADS*ST_W-1:0] state_vec,
  input  logic [NUM_THREADS-1:0]      active,
  output logic [NUM_THREADS-1:0]      elig
);

  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
    assign elig[t] = active[t] & can_fetch(state_vec[t*ST_W +: ST_W]);
  end

endmodule

// File: rtl/fsel_first.sv
module fsel_first
  import fsel_pkg::*;
#(
  parameter int NUM_THREADS = 1
) (
  input  logic [NUM_THREADS-1:0] active,
  input  logic [NUM_THREADS-1:0] elig,
  output logic [TID_W-1:0]       tid,
  output logic                   hit
);

  always_comb begin
    tid = '0;
    hit = 1'b0;
    for (int t = NUM_THREADS-1; t >= 0; t--) begin
      if (active[t]) begin
        tid = TID_W'(t);
        hit = elig[t];
      end
    end
  end

endmodule

// File: rtl/fsel_rr_list.sv
module fsel_rr_list
  import fsel_pkg::*;
#(
  parameter int NUM_THREADS = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NUM_THREADS-1:0] elig,
  input  logic                   advance,
  output logic [TID_W-1:0]       tid,
  output logic                   hit
);

  localparam int POS_W = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1;

  logic [TID_W-1:0] order_q [NUM_THREADS];
  logic [TID_W-1:0] order_d [NUM_THREADS];
  logic [POS_W-1:0] pos;

  // scan from head: first eligible entry wins
  always_comb begin
    hit = 1'b0;
    pos = '0;
    for (int p = NUM_THREADS-1; p >= 0; p--) begin
      if (elig[order_q[p]]) begin
        hit = 1'b1;
        pos = POS_W'(p);
      end
    end
  end

  assign tid = order_q[pos];

  // next state: granted entry to tail, later entries close the gap
  always_comb begin
    for (int i = 0; i < NUM_THREADS; i++) order_d[i] = order_q[i];
    if (advance) begin
      for (int i = 0; i < NUM_THREADS-1; i++) begin
        if (i >= int'(pos)) order_d[i] = order_q[i+1];
      end
      order_d[NUM_THREADS-1] = order_q[pos];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_THREADS; i++) order_q[i] <= TID_W'(i);
    end else if (advance) begin
      for (int i = 0; i < NUM_THREADS; i++) order_q[i] <= order_d[i];
    end
  end

  logic [NUM_THREADS-1:0] seen;
  always_comb begin
    seen = '0;
    for (int i = 0; i < NUM_THREADS; i++) seen[order_q[i]] = 1'b1;
  end

  // R3
  list_perm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(seen) == NUM_THREADS);

  // R3
  tail_is_granted_chk: assert property (@(posedge clk) disable iff (!rst_n)
    advance |=> order_q[NUM_THREADS-1] == $past(tid));

  // R4
  list_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !advance |=> $stable(order_q[0]) && $stable(order_q[NUM_THREADS-1]));

  // R2
  grant_elig_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> elig[tid]);

endmodule

// File: rtl/fetch_thread_sel.sv
module fetch_thread_sel
  import fsel_pkg::*;
#(
  parameter int NUM_THREADS = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_THREADS*ST_W-1:0] thr_state,
  input  logic [NUM_THREADS-1:0]      thr_active,
  input  logic                        policy_rr,
  input  logic                        grant_accept,
  output logic [TID_W-1:0]            sel_tid,
  output logic                        sel_valid
);

  logic [NUM_THREADS-1:0] elig;

  fsel_elig #(.NUM_THREADS(NUM_THREADS)) u_elig (
    .state_vec (thr_state),
    .active    (thr_active),
    .elig      (elig)
  );

  if (NUM_THREADS == 1) begin : g_one
    logic unused_ins;
    assign unused_ins = clk ^ rst_n ^ policy_rr ^ grant_accept;

    fsel_first #(.NUM_THREADS(NUM_THREADS)) u_first (
      .active (thr_active),
      .elig   (elig),
      .tid    (sel_tid),
      .hit    (sel_valid)
    );
  end else begin : g_multi
    logic [TID_W-1:0] rr_tid;
    logic             rr_hit;
    logic             advance;

    assign advance = policy_rr & rr_hit & grant_accept;

    fsel_rr_list #(.NUM_THREADS(NUM_THREADS)) u_list (
      .clk     (clk),
      .rst_n   (rst_n),
      .elig    (elig),
      .advance (advance),
      .tid     (rr_tid),
      .hit     (rr_hit)
    );

    always_comb begin
      if (policy_rr) begin
        sel_tid   = rr_tid;
        sel_valid = rr_hit;
      end else begin
        sel_tid   = '0;
        sel_valid = 1'b1;
      end
    end

    // R1
    sel_fetchable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (policy_rr && sel_valid) |->
        (thr_active[sel_tid] && can_fetch(thr_state[int'(sel_tid)*ST_W +: ST_W])));

    // R5
    fixed_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !policy_rr |-> (sel_valid && sel_tid == '0));
  end

endmodule

// File: tb/tb_fetch_thread_sel.sv
`timescale 1ns/1ps
module tb_fetch_thread_sel;

  localparam int N = 4;

  logic         clk;
  logic         rst_n;
  logic [3*N-1:0] st;
  logic [N-1:0] act;
  logic         pol;
  logic         acc;
  logic [1:0]   tid;
  logic         vld;
  logic [2:0]   st1;
  logic [0:0]   act1;
  logic [1:0]   tid1;
  logic         vld1;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  int model [N];

  fetch_thread_sel #(.NUM_THREADS(N)) dut (
    .clk(clk), .rst_n(rst_n), .thr_state(st), .thr_active(act),
    .policy_rr(pol), .grant_accept(acc), .sel_tid(tid), .sel_valid(vld));

  fetch_thread_sel #(.NUM_THREADS(1)) dut_one (
    .clk(clk), .rst_n(rst_n), .thr_state(st1), .thr_active(act1),
    .policy_rr(pol), .grant_accept(acc), .sel_tid(tid1), .sel_valid(vld1));

  initial clk = 0;
  always #2 clk = ~clk;

  function automatic bit fetchable(input logic [2:0] s);
    return s <= 3'd2;
  endfunction

  function automatic bit elig_t(input int t);
    return act[t] && fetchable(st[t*3 +: 3]);
  endfunction

  task automatic check(input string req, input int got_t, input int got_v,
                       input int exp_t, input int exp_v);
    checks++;
    if (got_v != exp_v || (exp_v && got_t != exp_t)) begin
      fails++;
      $display("FAIL %s: tid=%0d valid=%0d expected tid=%0d valid=%0d",
               req, got_t, got_v, exp_t, exp_v);
    end
  endtask

  // compare this cycle, then advance the reference list (due next edge)
  task automatic eval_cycle(input string req);
    int et, ev, p;
    et = 0; ev = 0; p = -1;
    if (!pol) begin
      ev = 1; et = 0;
    end else begin
      for (int i = 0; i < N; i++) begin
        if (p < 0 && elig_t(model[i])) p = i;
      end
      if (p >= 0) begin ev = 1; et = model[p]; end
    end
    check(req, int'(tid), int'(vld), et, ev);
    // R8
    check("R8", int'(tid1), int'(vld1), 0, (act1[0] && fetchable(st1)) ? 1 : 0);
    // R3: rotation only on accepted valid rotating grant
    if (pol && p >= 0 && acc) begin
      int g;
      g = model[p];
      for (int i = p; i < N-1; i++) model[i] = model[i+1];
      model[N-1] = g;
    end
  endtask

  task automatic drive(input logic [3*N-1:0] s, input logic [N-1:0] a,
                       input logic p, input logic c, input string req);
    @(negedge clk);
    st = s; act = a; pol = p; acc = c;
    #1;
    eval_cycle(req);
  endtask

  localparam logic [11:0] ALL_RUN = 12'h000;
  localparam logic [11:0] ALL_BLK = {3'd4, 3'd4, 3'd4, 3'd4};

  initial begin
    rst_n = 0; st = ALL_RUN; act = '1; pol = 1; acc = 0; st1 = 0; act1 = 1;
    for (int i = 0; i < N; i++) model[i] = i;
    repeat (3) @(posedge clk);
    #1;
    // R6: reset list ascending, head is thread 0
    check("R6", int'(tid), int'(vld), 0, 1);
    @(negedge clk); rst_n = 1;

    // R6: ascending grant order then wrap
    for (int k = 0; k < 5; k++) drive(ALL_RUN, '1, 1, 1, "R6");

    // R7: no accept keeps the same grant
    drive(ALL_RUN, '1, 1, 0, "R7");
    drive(ALL_RUN, '1, 1, 0, "R7");

    // R1: each state code alone on thread 0, others blocked
    for (int c = 0; c < 8; c++) begin
      logic [11:0] s;
      s = ALL_BLK;
      s[2:0] = 3'(c);
      drive(s, '1, 1, 0, "R1");
    end
    // R1: inactive running thread is never chosen
    drive(ALL_RUN, 4'b0000, 1, 1, "R1");
    drive(ALL_RUN, 4'b0100, 1, 0, "R1");

    // R3: grant a middle entry, skipped ones keep order
    begin
      logic [11:0] s;
      s = ALL_BLK;
      s[model[2]*3 +: 3] = 3'd1;
      drive(s, '1, 1, 1, "R3");
    end
    for (int k = 0; k < 4; k++) drive(ALL_RUN, '1, 1, 1, "R3");

    // R4: accept with nothing eligible leaves list unchanged
    drive(ALL_BLK, '1, 1, 1, "R4");
    drive(ALL_RUN, '1, 1, 0, "R4");

    // R5: fixed mode with thread 0 blocked, accept does not rotate
    drive(ALL_BLK, 4'b0010, 0, 1, "R5");
    drive(ALL_RUN, '1, 0, 1, "R5");
    drive(ALL_RUN, '1, 1, 0, "R5");

    // R8: directed single-thread cases
    st1 = 3'd5; act1 = 1; drive(ALL_RUN, '1, 1, 0, "R2");
    st1 = 3'd2; act1 = 0; drive(ALL_RUN, '1, 1, 0, "R2");
    st1 = 3'd2; act1 = 1; drive(ALL_RUN, '1, 1, 0, "R2");

    // random mix: R2 / R4 / R5
    void'($urandom(32'd1234));
    for (int k = 0; k < 3000; k++) begin
      logic [11:0] s;
      logic [3:0]  a;
      logic        p;
      for (int t = 0; t < N; t++) s[t*3 +: 3] = 3'($urandom % 8);
      for (int t = 0; t < N; t++) a[t] = ($urandom % 4) != 0;
      p = ($urandom % 6) != 0;
      st1 = 3'($urandom % 8);
      act1 = 1'(($urandom % 4) != 0);
      drive(s, a, p, 1'(($urandom % 4) != 0), p ? "R2" : "R5");
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule